// File: doc/BRIEF.md
# Correlating Global-History Branch Predictor

This block guesses the direction of conditional branches. It keeps a short register of how the most recent branches resolved, as one bit per branch with 1 meaning taken. That history is joined with a few low bits of the branch address to pick one saturating counter from a fixed table. The upper bit of the chosen counter is the guess. Two branches that resolved differently just before the current one can therefore steer the current branch to different counters, even when it sits at the same address.

The fetch stage presents an address on the lookup side. It gets the guess back in the same cycle, together with the history value that produced it. The pipeline carries that history value along with the branch. When the branch resolves, the back end presents the address, the real outcome and the carried history on the update side. On the next clock edge the counter chosen by that carried history is moved one step toward the outcome, and the outcome bit is shifted into the history register. Table entries carry no tag, so different branches can share an entry without the block noticing.

Top module: `corr_bpred`

## Requirements
- R1: After reset, the history output reads 0 and every table counter holds 01, so every lookup predicts not-taken.
- R2: Each accepted update shifts the history one place toward its upper bit and puts the actual outcome (1 = taken) in bit 0.
- R3: In a cycle with no update, neither the history nor any counter changes, whatever the other update inputs carry.
- R4: The prediction is the top bit of the counter at index {history, pc[7:2]}. The history occupies the upper index bits, and the prediction appears in the same cycle as the lookup address.
- R5: A counter at 11 stays at 11 on a taken update. A single not-taken update after that still leaves it predicting taken.
- R6: A counter steps down by one on a not-taken update and stays at 00 once there. A single taken update after that still leaves it predicting not-taken.
- R7: An update writes the counter chosen by the history carried on the update port, not by the current history.
- R8: Addresses that differ only in bits [1:0] or in bits above bit 7 select the same counter.
- R9: One address under different history values uses independent counters.
- R10: A counter below 11 steps up by exactly one on a taken update, so 01 becomes 10 and the prediction turns to taken.
- R11: An update changes the prediction from the following cycle onward. A lookup to the same entry in the update cycle still sees the old counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pred_pc | input | 32 | Address of the branch being looked up |
| pred_taken | output | 1 | Guess for pred_pc, 1 = taken |
| pred_hist | output | 2 | Current global history, to be carried with the branch |
| upd_valid | input | 1 | An update is presented this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_hist | input | 2 | History value captured when this branch was predicted |

## Verification
The checker checks on every cycle that the history shifts or holds as required, that the prediction equals the top bit of the counter its own index computation selects, and that an updated counter moves by exactly one step or stays at its limit. The reset image of the whole table is checked at the first active edge. Aliasing across upper address bits, the separation of counters by history, the write going to the carried history rather than the live one, and the one-cycle delay before an update becomes visible are shown only by the bench's scenarios. The bench also sweeps every table entry under every history value against an arithmetic model.

// File: rtl/bp_pkg.sv
// Package: default sizes and counter state names shared by the predictor,
// its checker and its bench.
package bp_pkg;
    localparam int BP_HIST_W   = 2;   // outcomes held in the global history
    localparam int BP_CTR_W    = 2;   // bits per saturating counter
    localparam int BP_PC_IDX_W = 6;   // address bits taken from pc[7:2]
    localparam int BP_PC_W     = 32;  // address width

    // Names of the four states of a 2-bit counter
    typedef enum logic [1:0] {
        CTR2_STRONG_NT = 2'b00,
        CTR2_WEAK_NT   = 2'b01,
        CTR2_WEAK_T    = 2'b10,
        CTR2_STRONG_T  = 2'b11
    } ctr2_e;
endpackage

// File: rtl/bp_history.sv
// Global outcome history register.
// Shifts toward the upper bit and inserts bit_in at bit 0 when shift_en is set.
// Assumes HIST_W >= 1; resets to all zeros.
module bp_history #(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist_o
);
    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_nxt;

    // Next history value; a one-bit history simply takes the new outcome
    generate
        if (HIST_W == 1) begin : g_single
            assign hist_nxt = bit_in;
        end else begin : g_multi
            assign hist_nxt = {hist_q[HIST_W-2:0], bit_in};
        end
    endgenerate

    // History register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (shift_en) begin
            hist_q <= hist_nxt;
        end
    end

    assign hist_o = hist_q;
endmodule

// File: rtl/bp_index.sv
// Table index former: history in the upper bits, pc[PC_IDX_W+1:2] below it.
// Purely combinational. Assumes PC_W > PC_IDX_W + 2.
module bp_index #(
    parameter int HIST_W   = 2,
    parameter int PC_IDX_W = 6,
    parameter int PC_W     = 32,
    localparam int IDX_W   = HIST_W + PC_IDX_W
) (
    input  logic [HIST_W-1:0] hist_i,
    input  logic [PC_W-1:0]   pc_i,
    output logic [IDX_W-1:0]  idx_o
);
    logic unused_pc_bits;

    // Join history and word-address bits into one table index
    assign idx_o = {hist_i, pc_i[PC_IDX_W+1:2]};

    // Byte-offset and upper address bits are deliberately ignored
    assign unused_pc_bits = ^{pc_i[PC_W-1:PC_IDX_W+2], pc_i[1:0]};
endmodule

// File: rtl/bp_counter_table.sv
// Table of saturating direction counters.
// One read port (combinational, returns the counter's top bit) and one write
// port that steps the addressed counter toward wr_up, saturating at both ends.
// Reset loads every counter with the weak not-taken value 0b01..1.
// Assumes CTR_W >= 2.
module bp_counter_table #(
    parameter int IDX_W = 8,
    parameter int CTR_W = 2,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic                   rd_msb,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic                   wr_up,
    output logic [DEPTH*CTR_W-1:0] ctr_flat
);
    localparam logic [CTR_W-1:0] C_INIT = {1'b0, {(CTR_W-1){1'b1}}};
    localparam logic [CTR_W-1:0] C_MAX  = '1;
    localparam logic [CTR_W-1:0] C_MIN  = '0;

    logic [CTR_W-1:0] ctr_arr [DEPTH];
    logic [CTR_W-1:0] rd_ctr;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_ctr
            logic [CTR_W-1:0] cq;
            logic             hit;

            assign hit = wr_en && (wr_idx == IDX_W'(g));

            // Per-entry counter: saturating step on a write hit
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cq <= C_INIT;
                end else if (hit) begin
                    if (wr_up && (cq != C_MAX)) begin
                        cq <= cq + 1'b1;
                    end else if (!wr_up && (cq != C_MIN)) begin
                        cq <= cq - 1'b1;
                    end
                end
            end

            assign ctr_arr[g]                    = cq;
            assign ctr_flat[g*CTR_W +: CTR_W]    = cq;
        end
    endgenerate

    // Read port: select the counter and take its direction bit
    assign rd_ctr = ctr_arr[rd_idx];
    assign rd_msb = rd_ctr[CTR_W-1];
endmodule

// File: rtl/corr_bpred.sv
// Correlating branch predictor top.
// Lookup: index = {global history, pred_pc word bits}; the guess is the
// counter's top bit, returned combinationally with the history used.
// Update: the counter chosen by the carried history (upd_hist) steps toward
// the outcome, and the outcome is shifted into the history, on one edge.
// Assumes the pipeline carries pred_hist to upd_hist unchanged.
module corr_bpred
    import bp_pkg::*;
#(
    parameter int HIST_W   = BP_HIST_W,
    parameter int CTR_W    = BP_CTR_W,
    parameter int PC_IDX_W = BP_PC_IDX_W,
    parameter int PC_W     = BP_PC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   pred_pc,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_hist,
    input  logic              upd_valid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic              upd_taken,
    input  logic [HIST_W-1:0] upd_hist
);
    localparam int IDX_W = HIST_W + PC_IDX_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0]      hist_q;
    logic [IDX_W-1:0]       rd_idx;
    logic [IDX_W-1:0]       wr_idx;
    logic [DEPTH*CTR_W-1:0] ctr_flat;

    // Global history of resolved outcomes
    bp_history #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (upd_valid),
        .bit_in   (upd_taken),
        .hist_o   (hist_q)
    );

    // Lookup index from the live history
    bp_index #(.HIST_W(HIST_W), .PC_IDX_W(PC_IDX_W), .PC_W(PC_W)) u_rd_ix (
        .hist_i (hist_q),
        .pc_i   (pred_pc),
        .idx_o  (rd_idx)
    );

    // Update index from the history carried with the branch
    bp_index #(.HIST_W(HIST_W), .PC_IDX_W(PC_IDX_W), .PC_W(PC_W)) u_wr_ix (
        .hist_i (upd_hist),
        .pc_i   (upd_pc),
        .idx_o  (wr_idx)
    );

    // Counter table
    bp_counter_table #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_tab (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_msb   (pred_taken),
        .wr_en    (upd_valid),
        .wr_idx   (wr_idx),
        .wr_up    (upd_taken),
        .ctr_flat (ctr_flat)
    );

    assign pred_hist = hist_q;
endmodule

// File: rtl/corr_bpred_chk.sv
// Checker for corr_bpred, bound to every instance.
// Computes its own indices from the ports and watches the table image.
module corr_bpred_chk #(
    parameter int HIST_W   = 2,
    parameter int CTR_W    = 2,
    parameter int PC_IDX_W = 6,
    parameter int PC_W     = 32,
    localparam int IDX_W   = HIST_W + PC_IDX_W,
    localparam int DEPTH   = 1 << IDX_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PC_W-1:0]        pred_pc,
    input  logic                   pred_taken,
    input  logic [HIST_W-1:0]      pred_hist,
    input  logic                   upd_valid,
    input  logic [PC_W-1:0]        upd_pc,
    input  logic                   upd_taken,
    input  logic [HIST_W-1:0]      upd_hist,
    input  logic [DEPTH*CTR_W-1:0] ctr_flat
);
    localparam logic [CTR_W-1:0] K_INIT = {1'b0, {(CTR_W-1){1'b1}}};
    localparam logic [CTR_W-1:0] K_MAX  = '1;
    localparam logic [CTR_W-1:0] K_MIN  = '0;

    logic [CTR_W-1:0] view [DEPTH];
    logic [IDX_W-1:0] li;
    logic [IDX_W-1:0] ui;
    logic [CTR_W-1:0] li_ctr;
    logic [CTR_W-1:0] ui_ctr;
    logic             v_q;
    logic             t_q;
    logic [IDX_W-1:0] ui_q;
    logic [CTR_W-1:0] old_q;
    logic [CTR_W-1:0] cur_q;
    logic             unused_chk_bits;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_view
            assign view[g] = ctr_flat[g*CTR_W +: CTR_W];
        end
    endgenerate

    assign li     = {pred_hist, pred_pc[PC_IDX_W+1:2]};
    assign ui     = {upd_hist, upd_pc[PC_IDX_W+1:2]};
    assign li_ctr = view[li];
    assign ui_ctr = view[ui];
    assign cur_q  = view[ui_q];
    assign unused_chk_bits = ^{pred_pc[PC_W-1:PC_IDX_W+2], pred_pc[1:0],
                               upd_pc[PC_W-1:PC_IDX_W+2], upd_pc[1:0]};

    // Remember the last update and the counter value it started from
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q   <= 1'b0;
            t_q   <= 1'b0;
            ui_q  <= '0;
            old_q <= '0;
        end else begin
            v_q   <= upd_valid;
            t_q   <= upd_taken;
            ui_q  <= ui;
            old_q <= ui_ctr;
        end
    end

    // R1: first active edge sees cleared history and the reset table image
    p_reset_image_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pred_hist == '0) && (ctr_flat == {DEPTH{K_INIT}}));

    // R2: an update shifts its outcome into bit 0
    generate
        if (HIST_W == 1) begin : g_sh1
            p_hist_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
                upd_valid |=> pred_hist[0] == $past(upd_taken));
        end else begin : g_shn
            p_hist_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
                upd_valid |=> pred_hist == {$past(pred_hist[HIST_W-2:0]), $past(upd_taken)});
        end
    endgenerate

    // R3: no update leaves the history alone
    p_hist_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(pred_hist));

    // R3: no update leaves the whole table alone
    p_table_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(ctr_flat));

    // R4: prediction is the top bit of the independently indexed counter
    p_pred_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken == li_ctr[CTR_W-1]);

    // R5: saturation at the top
    p_sat_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q && t_q && (old_q == K_MAX)) |-> (cur_q == K_MAX));

    // R6: one step down below a non-zero value
    p_step_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q && !t_q && (old_q != K_MIN)) |-> (cur_q == old_q - 1'b1));

    // R6: saturation at the bottom
    p_sat_bottom_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q && !t_q && (old_q == K_MIN)) |-> (cur_q == K_MIN));

    // R10: one step up below the top value
    p_step_up_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q && t_q && (old_q != K_MAX)) |-> (cur_q == old_q + 1'b1));
endmodule

bind corr_bpred corr_bpred_chk #(
    .HIST_W   (HIST_W),
    .CTR_W    (CTR_W),
    .PC_IDX_W (PC_IDX_W),
    .PC_W     (PC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pred_pc    (pred_pc),
    .pred_taken (pred_taken),
    .pred_hist  (pred_hist),
    .upd_valid  (upd_valid),
    .upd_pc     (upd_pc),
    .upd_taken  (upd_taken),
    .upd_hist   (upd_hist),
    .ctr_flat   (ctr_flat)
);

// File: tb/sim_corr_bpred.sv
// Bench for corr_bpred at its default configuration: a table model computed
// arithmetically, directed corner cases, a pseudo-random update stream and
// an exhaustive sweep of all entries under all history values.
module sim_corr_bpred;
    localparam int HW    = 2;
    localparam int NPC   = 64;
    localparam int DEPTH = 256;
    localparam logic [31:0] PC_A = 32'h0000_0040;
    localparam logic [31:0] PC_B = 32'h0000_0080;
    localparam logic [31:0] PC_C = 32'h0000_0020;
    localparam logic [31:0] PC_X = 32'h0000_00FC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pred_pc = '0;
    logic        pred_taken;
    logic [1:0]  pred_hist;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [1:0]  upd_hist = '0;

    int n_chk = 0;
    int n_err = 0;
    int mctr [DEPTH];
    int mhist = 0;
    logic [31:0] lf = 32'h1234_5679;

    always #10 clk = ~clk;

    corr_bpred u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .pred_pc    (pred_pc),
        .pred_taken (pred_taken),
        .pred_hist  (pred_hist),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_taken  (upd_taken),
        .upd_hist   (upd_hist)
    );

    function automatic int midx(int h, logic [31:0] pc);
        return ((h & 3) << 6) | int'((pc >> 2) & 32'h3F);
    endfunction

    function automatic void mdl_upd(logic [31:0] pc, bit t, int h);
        int i;
        i = midx(h, pc);
        if (t && mctr[i] < 3) mctr[i] = mctr[i] + 1;
        else if (!t && mctr[i] > 0) mctr[i] = mctr[i] - 1;
        mhist = ((mhist << 1) | int'(t)) & 3;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic resolve(logic [31:0] pc, bit t, int h);
        @(negedge clk);
        upd_pc    = pc;
        upd_taken = t;
        upd_hist  = 2'(h);
        upd_valid = 1'b1;
        @(negedge clk);
        upd_valid = 1'b0;
        mdl_upd(pc, t, h);
    endtask

    task automatic set_hist(int h);
        resolve(PC_X, bit'((h >> 1) & 1), mhist);
        resolve(PC_X, bit'(h & 1), mhist);
    endtask

    task automatic look(logic [31:0] pc, string tag);
        int exp;
        @(negedge clk);
        pred_pc = pc;
        #1;
        exp = (mctr[midx(mhist, pc)] >= 2) ? 1 : 0;
        check(int'(pred_taken) == exp, tag, int'(pred_taken), exp);
        check(int'(pred_hist) == mhist, {tag, " history"}, int'(pred_hist), mhist);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        bit ref_t;
        int hold_h;
        for (int i = 0; i < DEPTH; i++) mctr[i] = 1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state over every address at history 0
        check(pred_hist == 2'b00, "R1 history after reset", int'(pred_hist), 0);
        for (int p = 0; p < NPC; p++) begin
            look(32'(p << 2), "R1 reset prediction");
        end

        // R11 and R10: same-entry lookup during the update cycle
        set_hist(3);
        @(negedge clk);
        pred_pc   = PC_A;
        upd_pc    = PC_A;
        upd_taken = 1'b1;
        upd_hist  = 2'd3;
        upd_valid = 1'b1;
        #1;
        check(pred_taken == 1'b0, "R11 old value in update cycle", int'(pred_taken), 0);
        @(negedge clk);
        upd_valid = 1'b0;
        mdl_upd(PC_A, 1'b1, 3);
        #1;
        check(pred_taken == 1'b1, "R10 01 steps to 10 after one edge", int'(pred_taken), 1);
        check(pred_hist == 2'd3, "R2 history after taken", int'(pred_hist), 3);

        // R5: saturate at 11, then one not-taken still predicts taken
        for (int k = 0; k < 4; k++) resolve(PC_A, 1'b1, 0);
        set_hist(0);
        look(PC_A, "R5 trained taken");
        resolve(PC_A, 1'b0, 0);
        set_hist(0);
        look(PC_A, "R5 saturated top survives one not-taken");
        check(pred_taken == 1'b1, "R5 explicit taken", int'(pred_taken), 1);

        // R6: saturate at 00, then one taken still predicts not-taken
        for (int k = 0; k < 4; k++) resolve(PC_B, 1'b0, 0);
        resolve(PC_B, 1'b1, 0);
        set_hist(0);
        look(PC_B, "R6 saturated bottom survives one taken");
        check(pred_taken == 1'b0, "R6 explicit not-taken", int'(pred_taken), 0);

        // R7 and R9: update by carried history, not the live one
        set_hist(2);
        resolve(PC_C, 1'b1, 1);
        resolve(PC_C, 1'b1, 1);
        set_hist(2);
        look(PC_C, "R7 live-history entry untouched");
        check(pred_taken == 1'b0, "R7 explicit untouched", int'(pred_taken), 0);
        set_hist(1);
        look(PC_C, "R9 carried-history entry trained");
        check(pred_taken == 1'b1, "R9 explicit trained", int'(pred_taken), 1);

        // R8: aliasing on byte offset and upper address bits
        set_hist(0);
        look(PC_A, "R8 base");
        ref_t = pred_taken;
        look(PC_A | 32'h3, "R8 byte offset alias");
        check(pred_taken == ref_t, "R8 offset alias matches", int'(pred_taken), int'(ref_t));
        look(PC_A + 32'h0001_0100, "R8 upper bits alias");
        check(pred_taken == ref_t, "R8 upper alias matches", int'(pred_taken), int'(ref_t));

        // R3: idle cycles with noisy update inputs change nothing
        hold_h = mhist;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            upd_pc    = PC_A;
            upd_taken = bit'(k & 1);
            upd_hist  = 2'(k);
        end
        check(int'(pred_hist) == hold_h, "R3 history held", int'(pred_hist), hold_h);
        look(PC_A, "R3 counter held");

        // R2 and R4: pseudo-random update stream against the model
        for (int k = 0; k < 1500; k++) begin
            int h;
            lf = lf[31] ? ((lf << 1) ^ 32'h04C1_1DB7) : (lf << 1);
            h  = lf[5] ? mhist : int'(lf[9:8]);
            resolve(lf, lf[17], h);
            look({lf[15:0], lf[31:16]}, "R2 R4 random stream");
        end

        // R4 and R9: exhaustive sweep of every entry under every history
        for (int h = 0; h < 4; h++) begin
            set_hist(h);
            for (int p = 0; p < NPC; p++) begin
                look(32'(p << 2) | 32'h0000_0300, "R4 R9 sweep");
            end
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule